// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the pending-interrupt flags and the per-source enable bits for three timer/counters. It turns them into one interrupt request with the vector address of the most urgent source. Each timer sends single-cycle event pulses into it: compare matches, counter overflows and an input-capture trigger. Each pulse sets a flag. A flag stays set until one of two things happens. The CPU may acknowledge the flag's vector, or software may write a one to the flag's bit.

A small register port reads and writes two 8-bit registers: the flag register and the mask register. A source raises a request only when three bits are all one: its flag, its mask bit and the global interrupt-enable input. When several sources request at once, the source with the lowest vector address is presented. The request and vector outputs are combinational from registered state. An acknowledge names a vector address and clears only the flag mapped to that address.

Top module: `timer_irq_unit`

## Requirements
- R1: Event bit, flag bit and mask bit share one position per source: 7 timer-2 compare, 6 timer-2 overflow, 5 timer-1 capture, 4 timer-1 compare A, 3 timer-1 compare B, 2 timer-1 overflow, 0 timer-0 overflow.
- R2: Bit 1 of the flag register and of the mask register always reads zero. Events and writes at bit 1 have no effect.
- R3: After reset, both registers read zero and `irq_o` is low.
- R4: An event pulse at a source's bit position sets that flag on the next clock edge.
- R5: An acknowledge with `ack_vec_i` equal to a source's vector clears that flag only. An acknowledge naming an address no source owns changes nothing.
- R6: Writing the flag register (`reg_sel_i`=0) clears each flag whose data bit is one and leaves each flag whose data bit is zero unchanged.
- R7: If an event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is one exactly when `gie_i` is one and some flag and its mask bit are both one.
- R9: The vectors are bit7 0x006, bit6 0x008, bit5 0x00A, bit4 0x00C, bit3 0x00E, bit2 0x010, bit0 0x012. `irq_vec_o` is zero while `irq_o` is low.
- R10: Among the requesting sources, the one with the lowest vector address drives `irq_vec_o`.
- R11: The mask register (`reg_sel_i`=1) is plain read/write. The value written appears on the next read, apart from bit 1.
- R12: `reg_rdata_o` is combinational and shows the register selected by `reg_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Single-cycle event pulses, one per flag bit position |
| gie_i | input | 1 | Global interrupt enable |
| reg_sel_i | input | 1 | Register select: 0 flags, 1 mask |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| ack_i | input | 1 | Vector taken |
| ack_vec_i | input | 12 | Address of the vector taken |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 12 | Vector address of the winning source |

## Verification
The bench builds the block with the default parameters: an 8-bit register width, a 12-bit vector width, the reserved position at bit 1, vector base 0x006 and step 2. With these values the complete bit layout, all seven vector addresses and the reserved-bit gap in the vector sequence are within reach. A cycle model in the bench tracks every mix of events, write-ones, acknowledges and enable settings.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int TIF_DW   = 8;
  localparam int TIF_VW   = 12;
  localparam int TIF_RSVD = 1;
  localparam int TIF_BASE = 6;
  localparam int TIF_STEP = 2;

  typedef enum logic {SEL_FLAG = 1'b0, SEL_MASK = 1'b1} tif_sel_e;

  // Higher bit position -> lower vector; the reserved slot takes no vector.
  function automatic int tif_vec(int b, int w, int rsvd, int base, int step);
    return base + step * ((b > rsvd) ? (w - 1 - b) : (w - 2 - b));
  endfunction
endpackage

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int DW   = tif_pkg::TIF_DW,
  parameter int VW   = tif_pkg::TIF_VW,
  parameter int RSVD = tif_pkg::TIF_RSVD,
  parameter int BASE = tif_pkg::TIF_BASE,
  parameter int STEP = tif_pkg::TIF_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  input  logic [VW-1:0] ack_vec_i,
  output logic [DW-1:0] flag_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == RSVD) begin : g_rsvd
      logic unused_in;
      assign unused_in = evt_i[b] ^ wdata_i[b];
      assign flag_o[b] = 1'b0;
    end else begin : g_flag
      localparam logic [VW-1:0] MY_VEC = VW'(tif_pkg::tif_vec(b, DW, RSVD, BASE, STEP));
      logic clr;
      assign clr = (wr_i && wdata_i[b]) || (ack_i && (ack_vec_i == MY_VEC));
      always_ff @(posedge clk) begin
        if (!rst_n) flag_o[b] <= 1'b0;
        else        flag_o[b] <= evt_i[b] | (flag_o[b] & ~clr);
      end

      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[b] |=> flag_o[b]);                                   // R7
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt_i[b]) |=> !flag_o[b]);                        // R5
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt_i[b]) |=> $stable(flag_o[b]));               // R6
    end
  end
endmodule

// File: rtl/tif_mask_reg.sv
module tif_mask_reg #(
  parameter int DW   = tif_pkg::TIF_DW,
  parameter int RSVD = tif_pkg::TIF_RSVD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);
  localparam logic [DW-1:0] KEEP = ~(DW'(1) << RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i & KEEP;
  end

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == ($past(wdata_i) & KEEP)));                 // R11
endmodule

// File: rtl/tif_prio.sv
module tif_prio #(
  parameter int DW   = tif_pkg::TIF_DW,
  parameter int VW   = tif_pkg::TIF_VW,
  parameter int RSVD = tif_pkg::TIF_RSVD,
  parameter int BASE = tif_pkg::TIF_BASE,
  parameter int STEP = tif_pkg::TIF_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] req_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  logic [DW-1:0] grant;

  // Ascending scan: a later (higher) position overrides, giving it priority.
  always_comb begin
    grant = '0;
    vec_o = '0;
    for (int b = 0; b < DW; b++) begin
      if (b != RSVD && req_i[b]) begin
        grant = '0;
        grant[b] = 1'b1;
        vec_o = VW'(tif_pkg::tif_vec(b, DW, RSVD, BASE, STEP));
      end
    end
  end
  assign irq_o = |grant;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));                                              // R10
  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_i) == '0);                                       // R10
  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (req_i != '0));                                       // R8
endmodule

// File: rtl/timer_irq_unit.sv
module timer_irq_unit #(
  parameter int DW   = tif_pkg::TIF_DW,
  parameter int VW   = tif_pkg::TIF_VW,
  parameter int RSVD = tif_pkg::TIF_RSVD,
  parameter int BASE = tif_pkg::TIF_BASE,
  parameter int STEP = tif_pkg::TIF_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          gie_i,
  input  logic          reg_sel_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          ack_i,
  input  logic [VW-1:0] ack_vec_i,
  output logic          irq_o,
  output logic [VW-1:0] irq_vec_o
);
  import tif_pkg::*;

  logic [DW-1:0] flags, mask, req;
  logic          wr_flag, wr_mask;

  assign wr_flag = reg_wr_i && (tif_sel_e'(reg_sel_i) == SEL_FLAG);
  assign wr_mask = reg_wr_i && (tif_sel_e'(reg_sel_i) == SEL_MASK);

  tif_flag_bank #(.DW(DW), .VW(VW), .RSVD(RSVD), .BASE(BASE), .STEP(STEP)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_i(wr_flag), .wdata_i(reg_wdata_i),
    .ack_i(ack_i), .ack_vec_i(ack_vec_i), .flag_o(flags));

  tif_mask_reg #(.DW(DW), .RSVD(RSVD)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_mask), .wdata_i(reg_wdata_i), .mask_o(mask));

  assign req = flags & mask & {DW{gie_i}};

  tif_prio #(.DW(DW), .VW(VW), .RSVD(RSVD), .BASE(BASE), .STEP(STEP)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(req), .irq_o(irq_o), .vec_o(irq_vec_o));

  assign reg_rdata_o = (tif_sel_e'(reg_sel_i) == SEL_MASK) ? mask : flags;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_i);                                              // R8
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_vec_o == '0));                                 // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[RSVD]);                                           // R2
endmodule

// File: tb/tb_timer_irq_unit.sv
module tb_timer_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic        gie_i;
  logic        reg_sel_i;
  logic        reg_wr_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  reg_rdata_o;
  logic        ack_i;
  logic [11:0] ack_vec_i;
  logic        irq_o;
  logic [11:0] irq_vec_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_flg = '0;
  logic [7:0] m_msk = '0;

  always #2 clk = ~clk;

  timer_irq_unit dut (.*);

  // R9: independent vector table.
  function automatic logic [11:0] bvec(int b);
    case (b)
      7: return 12'h006;  6: return 12'h008;  5: return 12'h00A;
      4: return 12'h00C;  3: return 12'h00E;  2: return 12'h010;
      0: return 12'h012;  default: return 12'h000;
    endcase
  endfunction

  // R10: lowest vector among pending requests.
  function automatic logic [11:0] exp_vec(logic [7:0] f, logic [7:0] m, logic g);
    logic [11:0] best = '0;
    for (int b = 0; b < 8; b++)
      if (g && f[b] && m[b] && b != 1 && (best == 0 || bvec(b) < best)) best = bvec(b);
    return best;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R8 irq", 32'(irq_o), 32'(gie_i && ((m_flg & m_msk) != 0)));
    chk("R9/R10 vector", 32'(irq_vec_o), 32'(exp_vec(m_flg, m_msk, gie_i)));
    chk("R12 readback", 32'(reg_rdata_o), 32'(reg_sel_i ? m_msk : m_flg));
  endtask

  // Drive at negedge, let one edge pass, update the model, check at negedge.
  task automatic step(logic [7:0] e, logic w, logic s, logic [7:0] d,
                      logic a, logic [11:0] av, logic g);
    logic [7:0] nf;
    evt_i = e; reg_wr_i = w; reg_sel_i = s; reg_wdata_i = d;
    ack_i = a; ack_vec_i = av; gie_i = g;
    @(posedge clk);
    for (int b = 0; b < 8; b++) begin
      logic clr = (w && !s && d[b]) || (a && av == bvec(b));
      nf[b] = (b == 1) ? 1'b0 : (e[b] | (m_flg[b] & ~clr));
    end
    m_flg = nf;
    if (w && s) m_msk = d & 8'hFD;
    @(negedge clk);
    evt_i = '0; reg_wr_i = 1'b0; ack_i = 1'b0;
    check_all();
  endtask

  task automatic peek(logic s, logic [7:0] exp, string req);
    reg_sel_i = s;
    #1;
    chk(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; evt_i = '0; gie_i = 1'b1; reg_sel_i = 1'b0; reg_wr_i = 1'b0;
    reg_wdata_i = '0; ack_i = 1'b0; ack_vec_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R3
    peek(1'b0, 8'h00, "R3 flags after reset");
    peek(1'b1, 8'h00, "R3 mask after reset");
    chk("R3 irq after reset", 32'(irq_o), 0);
    // R11 R2
    step(8'h00, 1, 1, 8'hFF, 0, 0, 1);
    peek(1'b1, 8'hFD, "R11/R2 mask write");
    // R4 R1 R2
    step(8'hFF, 0, 0, 0, 0, 0, 1);
    peek(1'b0, 8'hFD, "R4/R2 events set flags");
    chk("R10 top priority", 32'(irq_vec_o), 32'h006);
    // R6
    step(8'h00, 1, 0, 8'h80, 0, 0, 1);
    peek(1'b0, 8'h7D, "R6 write-one clears, zero keeps");
    chk("R9 next vector", 32'(irq_vec_o), 32'h008);
    // R5
    step(8'h00, 0, 0, 0, 1, 12'h008, 1);
    peek(1'b0, 8'h3D, "R5 ack clears one flag");
    step(8'h00, 0, 0, 0, 1, 12'h004, 1);
    peek(1'b0, 8'h3D, "R5 unowned ack no effect");
    // R7
    step(8'h20, 1, 0, 8'h20, 0, 0, 1);
    peek(1'b0, 8'h3D, "R7 event beats write-one");
    step(8'h20, 0, 0, 0, 1, 12'h00A, 1);
    peek(1'b0, 8'h3D, "R7 event beats ack");
    // R8
    step(8'h00, 0, 0, 0, 0, 0, 0);
    chk("R8 gie low blocks irq", 32'(irq_o), 0);
    // R9 lowest source
    step(8'h00, 1, 0, 8'hFC, 0, 0, 1);
    chk("R9 timer0 vector", 32'(irq_vec_o), 32'h012);
    step(8'h00, 1, 1, 8'h00, 0, 0, 1);
    chk("R8 mask blocks irq", 32'(irq_o), 0);
    // R2 event on reserved slot
    step(8'h02, 1, 0, 8'h01, 0, 0, 1);
    peek(1'b0, 8'h00, "R2 reserved event ignored");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  e  = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      logic        w  = ($urandom % 4 == 0);
      logic        a  = ($urandom % 4 == 0);
      logic [11:0] av;
      case ($urandom % 3)
        0: av = irq_vec_o;
        1: av = bvec(int'($urandom % 8));
        default: av = 12'h004;
      endcase
      step(e, w, 1'($urandom), 8'($urandom), a, av, ($urandom % 5 != 0));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule